// File: doc/BRIEF.md
# Segment Register Address Translator

This block turns a 32-bit effective address into a 52-bit virtual address. The four most significant address bits pick one of sixteen segment registers. The 24-bit segment identifier held in that register takes the place of those four bits. The remaining 28 bits, a 16-bit page index followed by a 12-bit byte offset, pass through to the low end of the virtual address unchanged. Translation requests arrive on a valid/ready stream, and each result leaves on a registered valid/ready stream one cycle after it is accepted.

The bank is split into two halves. Registers 0 to 7 form the user half, and a context switch reloads all of them in one cycle from a single base identifier: register n receives the base with its low three bits replaced by n. The eight identifiers of one context are therefore consecutive and aligned. Registers 8 to 15 form the kernel half, which a context switch never changes. Kernel setup code writes any single register through a separate index/data/write-enable port.

Back-pressure follows one rule: a request is taken when the output holds no result or the held result is taken in the same cycle. While a result is held and not accepted, it stays frozen and no new request is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and all sixteen segment registers read as zero, so a request to any segment returns identifier 0.
- R2: A request accepted in a cycle (`req_valid` and `req_ready` both high at the clock edge) produces `rsp_valid`=1 after that edge, with `rsp_va[51:28]` equal to the register selected by `req_ea[31:28]` and `rsp_va[27:0]` equal to `req_ea[27:0]`.
- R3: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_va` and `rsp_valid` hold their values on the next edge.
- R4: A cycle with `ctx_load` high sets each user register n (n = 0..7) to the base with bits [2:0] replaced by n.
- R5: `ctx_load` leaves registers 8 to 15 unchanged.
- R6: Bits [2:0] of `ctx_base` are ignored. Only bits [23:3] reach the user registers.
- R7: `sr_we` high writes `sr_data` into the register numbered `sr_idx`. Requests accepted after that edge see the new value.
- R8: A request accepted at the same edge as a `ctx_load` or `sr_we` update is translated with the register values from before that update.
- R9: When `ctx_load` and `sr_we` are high in the same cycle, the context load wins for user registers. A single write to a kernel register still takes effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ea | input | 32 | Effective address; bits [31:28] select the segment |
| rsp_valid | output | 1 | Translated address held on `rsp_va` |
| rsp_ready | input | 1 | Consumer takes the held result |
| rsp_va | output | 52 | Virtual address: {identifier, ea[27:0]} |
| ctx_load | input | 1 | Reload user registers 0..7 from `ctx_base` |
| ctx_base | input | 24 | Context base identifier; low three bits ignored |
| sr_we | input | 1 | Write one segment register |
| sr_idx | input | 4 | Register number for `sr_we` |
| sr_data | input | 24 | Identifier written by `sr_we` |

## Verification
The bench drives the case where a request and a bank update land on the same edge. A design that lets the new value bypass into the result would report the new identifier instead of the old one. It loads a base with its low bits set; a design that adds the base to n instead of replacing the low bits would produce identifiers that spill across alignment. It checks that the kernel half keeps its values through a context load, and it raises `ctx_load` and `sr_we` together against both a user register and a kernel register, which exposes a wrong priority or a kernel write that gets dropped. Holding `rsp_ready` low while new requests wait shows whether a stalled result gets overwritten or a request is wrongly taken.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  // Source of the next value for one segment register
  typedef enum logic [1:0] {
    SRC_KEEP   = 2'd0,
    SRC_CTX    = 2'd1,
    SRC_SINGLE = 2'd2
  } sr_src_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import sgx_pkg::*;
#(
  parameter int SEG_BITS = 4,
  parameter int VSID_W   = 24
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ctx_load,
  input  logic [VSID_W-1:0]                    ctx_base,
  input  logic                                 sr_we,
  input  logic [SEG_BITS-1:0]                  sr_idx,
  input  logic [VSID_W-1:0]                    sr_data,
  output logic [(1<<SEG_BITS)-1:0][VSID_W-1:0] sr_bank
);
  localparam int NUM      = 1 << SEG_BITS;
  localparam int HALF     = NUM / 2;
  localparam int CTX_BITS = SEG_BITS - 1;
  localparam logic [VSID_W-1:0] ALIGN_MASK = ~VSID_W'((1 << CTX_BITS) - 1);

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    localparam bit IS_USER = (i < HALF);
    logic [VSID_W-1:0] q;
    sr_src_e           src;

    always_comb begin
      src = SRC_KEEP;
      if (sr_we && (sr_idx == SEG_BITS'(i))) src = SRC_SINGLE;
      if (IS_USER && ctx_load) src = SRC_CTX;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        case (src)
          SRC_CTX:    q <= (ctx_base & ALIGN_MASK) | VSID_W'(i);
          SRC_SINGLE: q <= sr_data;
          default:    q <= q;
        endcase
      end
    end

    assign sr_bank[i] = q;
  end
endmodule

// File: rtl/seg_xlate_stage.sv
module seg_xlate_stage #(
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int VSID_W   = 24
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [(1<<SEG_BITS)-1:0][VSID_W-1:0] sr_bank,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [EA_W-1:0]                      req_ea,
  output logic                                 rsp_valid,
  input  logic                                 rsp_ready,
  output logic [VSID_W+EA_W-SEG_BITS-1:0]      rsp_va
);
  localparam int OFF_W = EA_W - SEG_BITS;

  logic                accept;
  logic [SEG_BITS-1:0] seg_sel;
  logic [VSID_W-1:0]   vsid;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign seg_sel   = req_ea[EA_W-1 -: SEG_BITS];
  assign vsid      = sr_bank[seg_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_va    <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_va    <= {vsid, req_ea[OFF_W-1:0]};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int VSID_W   = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [EA_W-1:0]                    req_ea,
  output logic                               rsp_valid,
  input  logic                               rsp_ready,
  output logic [VSID_W+EA_W-SEG_BITS-1:0]    rsp_va,
  input  logic                               ctx_load,
  input  logic [VSID_W-1:0]                  ctx_base,
  input  logic                               sr_we,
  input  logic [SEG_BITS-1:0]                sr_idx,
  input  logic [VSID_W-1:0]                  sr_data
);
  localparam int NUM = 1 << SEG_BITS;

  logic [NUM-1:0][VSID_W-1:0] sr_bank;

  seg_bank #(
    .SEG_BITS(SEG_BITS),
    .VSID_W  (VSID_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctx_load(ctx_load),
    .ctx_base(ctx_base),
    .sr_we   (sr_we),
    .sr_idx  (sr_idx),
    .sr_data (sr_data),
    .sr_bank (sr_bank)
  );

  seg_xlate_stage #(
    .EA_W    (EA_W),
    .SEG_BITS(SEG_BITS),
    .VSID_W  (VSID_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_bank  (sr_bank),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_ea   (req_ea),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_va   (rsp_va)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int VSID_W   = 24
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 req_valid,
  input logic                                 req_ready,
  input logic [EA_W-1:0]                      req_ea,
  input logic                                 rsp_valid,
  input logic                                 rsp_ready,
  input logic [VSID_W+EA_W-SEG_BITS-1:0]      rsp_va,
  input logic                                 ctx_load,
  input logic [VSID_W-1:0]                    ctx_base,
  input logic                                 sr_we,
  input logic [(1<<SEG_BITS)-1:0][VSID_W-1:0] sr_bank
);
  localparam int NUM      = 1 << SEG_BITS;
  localparam int HALF     = NUM / 2;
  localparam int CTX_BITS = SEG_BITS - 1;
  localparam int OFF_W    = EA_W - SEG_BITS;
  localparam logic [VSID_W-1:0] KEEP_MASK = ~VSID_W'((1 << CTX_BITS) - 1);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_va)));

  // R3
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid && rsp_va[OFF_W-1:0] == $past(req_ea[OFF_W-1:0])));

  // R5
  kernel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && !sr_we) |=> $stable(sr_bank[NUM-1:HALF]));

  for (genvar n = 0; n < HALF; n++) begin : g_ctx
    // R4 R6
    ctx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_load |=> (sr_bank[n] == (($past(ctx_base) & KEEP_MASK) | VSID_W'(n))));
  end
endmodule

bind seg_xlate seg_xlate_chk #(
  .EA_W    (EA_W),
  .SEG_BITS(SEG_BITS),
  .VSID_W  (VSID_W)
) u_seg_xlate_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_ea   (req_ea),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_va   (rsp_va),
  .ctx_load (ctx_load),
  .ctx_base (ctx_base),
  .sr_we    (sr_we),
  .sr_bank  (sr_bank)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [51:0] rsp_va;
  logic        ctx_load = 1'b0;
  logic [23:0] ctx_base = '0;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_idx = '0;
  logic [23:0] sr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_ea   (req_ea),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_va   (rsp_va),
    .ctx_load (ctx_load),
    .ctx_base (ctx_base),
    .sr_we    (sr_we),
    .sr_idx   (sr_idx),
    .sr_data  (sr_data)
  );

  // {effective address, expected virtual address} after setup:
  // sr8=123456, sr15=ABCDEF, user base 000A48, sr9 never written
  localparam logic [83:0] VEC [0:5] = '{
    {32'h0123_4567, 52'h000A48_1234567},
    {32'h7FFF_FFFF, 52'h000A4F_FFFFFFF},
    {32'h8000_0000, 52'h123456_0000000},
    {32'hF00D_CAFE, 52'hABCDEF_00DCAFE},
    {32'h3ABC_0001, 52'h000A4B_ABC0001},
    {32'h9000_0010, 52'h000000_0000010}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] ea, input logic [51:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_ea    = ea;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " va"}, 64'(rsp_va), 64'(exp));
  endtask

  task automatic sr_write(input logic [3:0] idx, input logic [23:0] data);
    @(negedge clk);
    sr_we = 1'b1; sr_idx = idx; sr_data = data;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic ctx(input logic [23:0] base);
    @(negedge clk);
    ctx_load = 1'b1; ctx_base = base;
    @(negedge clk);
    ctx_load = 1'b0;
  endtask

  // request, optional context load and optional single write on one edge
  task automatic same_edge(input logic do_ctx, input logic [23:0] base,
                           input logic do_we, input logic [3:0] idx, input logic [23:0] data,
                           input logic [31:0] ea, input logic [51:0] exp, input string tag);
    @(negedge clk);
    ctx_load = do_ctx; ctx_base = base;
    sr_we = do_we; sr_idx = idx; sr_data = data;
    req_valid = 1'b1; req_ea = ea;
    @(negedge clk);
    ctx_load = 1'b0; sr_we = 1'b0; req_valid = 1'b0;
    chk({tag, " va"}, 64'(rsp_va), 64'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
    xlate(32'hC000_0000, 52'h000000_0000000, "R1 zero register");

    // setup: kernel writes (R7) and a context load (R4)
    sr_write(4'd8, 24'h123456);
    sr_write(4'd15, 24'hABCDEF);
    ctx(24'h000A48);

    // R2 R4 R7 table walk
    for (int k = 0; k < 6; k++) begin
      xlate(VEC[k][83:52], VEC[k][51:0], "R2 table");
    end

    // R7 single write to a user register
    sr_write(4'd4, 24'h0F0F0F);
    xlate(32'h4000_0042, 52'h0F0F0F_0000042, "R7 single write");

    // R6 low base bits ignored
    ctx(24'h00F00F);
    xlate(32'h0000_0001, 52'h00F008_0000001, "R6 seg0");
    xlate(32'h7000_0002, 52'h00F00F_0000002, "R6 seg7");

    // R5 kernel half kept through the load
    xlate(32'h8ABC_DEF0, 52'h123456_ABCDEF0, "R5 seg8");
    xlate(32'hF000_0003, 52'hABCDEF_0000003, "R5 seg15");

    // R8 request on the edge of an update sees old values
    same_edge(1'b1, 24'h111110, 1'b0, 4'd0, 24'h0,
              32'h1000_0000, 52'h00F009_0000000, "R8 ctx same edge");
    xlate(32'h1000_0000, 52'h111111_0000000, "R8 ctx after");
    same_edge(1'b0, 24'h0, 1'b1, 4'd8, 24'h777777,
              32'h8000_0005, 52'h123456_0000005, "R8 write same edge");
    xlate(32'h8000_0005, 52'h777777_0000005, "R8 write after");

    // R9 conflict between context load and single write
    same_edge(1'b1, 24'h222220, 1'b1, 4'd2, 24'h5A5A5A,
              32'h2000_0000, 52'h111112_0000000, "R9 user conflict old");
    xlate(32'h2000_0000, 52'h222222_0000000, "R9 user ctx wins");
    same_edge(1'b1, 24'h333330, 1'b1, 4'd9, 24'h0C0C0C,
              32'h9000_0000, 52'h000000_0000000, "R9 kernel conflict old");
    xlate(32'h9000_0000, 52'h0C0C0C_0000000, "R9 kernel write kept");
    xlate(32'h2000_0000, 52'h333332_0000000, "R9 user after second load");

    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h9000_0011;
    @(negedge clk);
    chk("R3 held valid", 64'(rsp_valid), 64'd1);
    chk("R3 ready low", 64'(req_ready), 64'd0);
    req_ea = 32'h2000_0022;
    repeat (3) @(negedge clk);
    chk("R3 held va", 64'(rsp_va), 64'h0C0C0C_0000011);
    chk("R3 still ready low", 64'(req_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 next valid", 64'(rsp_valid), 64'd1);
    chk("R3 next va", 64'(rsp_va), 64'h333332_0000022);
    @(negedge clk);
    chk("R3 drained", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule